// File: doc/BRIEF.md
# Eye Pattern Serializer

This block takes pairs of constellation coordinates from a demodulator and sends them, one frame per pair, down a single serial line to an external shift-register D/A converter. The converter's output drives an oscilloscope in X/Y mode to draw the eye diagram. Each frame holds 16 bits: the X byte comes first and the Y byte second, each sent most significant bit first. A serial clock goes with the data. Data changes only while that clock is low, so each bit is settled well before the rising edge where the converter samples it. After the last bit, a load strobe tells the converter to latch the word it has assembled.

The sample input uses a valid/ready handshake. `in_ready` is high only while the serializer is idle. A pair is taken on any cycle where `in_valid` and `in_ready` are both high. The producer is not stalled by back-pressure. Any cycle where `in_valid` is high and `in_ready` is low discards that pair and adds one to a saturating drop counter. The serial clock is the system clock divided by a parameter, and it stays low between frames.

Top module: `eye_serializer`

## Requirements
- R1: During and right after reset, `eye_clk`, `eye_data` and `eye_strobe` are low, `in_ready` is high and `drop_count` is zero.
- R2: Each frame has exactly 16 rising edges of `eye_clk`. The bits sampled on those edges are `in_x[7]` down to `in_x[0]`, then `in_y[7]` down to `in_y[0]`.
- R3: `eye_data` holds steady for as long as `eye_clk` is high. It changes only while `eye_clk` is low.
- R4: Within a frame, each high and each low phase of `eye_clk` lasts DIV_HALF system cycles. `eye_clk` is low whenever `in_ready` is high.
- R5: `eye_strobe` rises on the same system edge as the 16th falling edge of `eye_clk`. It stays high for 2*DIV_HALF system cycles, and `eye_clk` stays low the whole time.
- R6: A pair is captured on the edge where `in_valid` and `in_ready` are both high. `in_ready` is low on the next cycle. Changes to `in_x`/`in_y` after capture do not affect the frame.
- R7: Each cycle with `in_valid` high and `in_ready` low increments `drop_count` by one. That pair is never transmitted.
- R8: `drop_count` saturates at 2**CNT_W-1.
- R9: `in_ready` rises on the same edge where `eye_strobe` falls. If `in_valid` is held high, the next frame's first rising edge of `eye_clk` comes DIV_HALF+1 cycles after the strobe's falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Coordinate pair valid |
| in_ready | output | 1 | Serializer idle, pair will be taken |
| in_x | input | COORD_W | X coordinate, two's complement |
| in_y | input | COORD_W | Y coordinate, two's complement |
| eye_data | output | 1 | Serial frame data, active high |
| eye_clk | output | 1 | Serial clock, data valid at its rising edge |
| eye_strobe | output | 1 | Load pulse for the external converter |
| drop_count | output | CNT_W | Saturating count of discarded pairs |

## Verification
The bench builds the block with DIV_HALF=3 and CNT_W=3. A divide ratio of 3 is neither 1 nor a power of two, so the clock-phase widths, the strobe length and the restart gap all give distinctive cycle counts while a whole frame stays near a hundred cycles. A three-bit drop counter reaches its saturation value of 7 within a single held burst of `in_valid` during one frame.

// File: rtl/eye_pkg.sv
package eye_pkg;
  typedef enum logic [1:0] {
    EYE_IDLE  = 2'd0,
    EYE_SHIFT = 2'd1,
    EYE_LOAD  = 2'd2
  } eye_state_t;
endpackage

// File: rtl/eye_half_timer.sv
module eye_half_timer #(
  parameter int DIV_HALF = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick,
  output logic phase
);
  logic at_end;

  generate
    if (DIV_HALF > 1) begin : g_count
      localparam int HW = $clog2(DIV_HALF);
      logic [HW-1:0] hcnt;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                         hcnt <= '0;
        else if (!run)                      hcnt <= '0;
        else if (hcnt == HW'(DIV_HALF - 1)) hcnt <= '0;
        else                                hcnt <= hcnt + 1'b1;
      end
      assign at_end = (hcnt == HW'(DIV_HALF - 1));
    end else begin : g_direct
      assign at_end = 1'b1;
    end
  endgenerate

  assign tick = run & at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    phase <= 1'b0;
    else if (!run) phase <= 1'b0;
    else if (tick) phase <= ~phase;
  end
endmodule

// File: rtl/eye_frame_ctrl.sv
module eye_frame_ctrl
  import eye_pkg::*;
#(
  parameter int COORD_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               accept,
  input  logic [COORD_W-1:0] x,
  input  logic [COORD_W-1:0] y,
  input  logic               tick,
  input  logic               phase,
  output eye_state_t         state,
  output logic               bit_out
);
  localparam int FW = 2 * COORD_W;
  localparam int BW = $clog2(FW);

  logic [FW-1:0] shreg;
  logic [BW-1:0] bcnt;
  logic          fall_tick;

  assign fall_tick = tick & phase;
  assign bit_out   = shreg[FW-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= EYE_IDLE;
      shreg <= '0;
      bcnt  <= '0;
    end else begin
      case (state)
        EYE_IDLE: begin
          if (accept) begin
            shreg <= {x, y};
            bcnt  <= '0;
            state <= EYE_SHIFT;
          end
        end
        EYE_SHIFT: begin
          if (fall_tick) begin
            shreg <= {shreg[FW-2:0], 1'b0};
            if (bcnt == BW'(FW - 1)) begin
              bcnt  <= '0;
              state <= EYE_LOAD;
            end else begin
              bcnt <= bcnt + 1'b1;
            end
          end
        end
        EYE_LOAD: begin
          if (fall_tick) state <= EYE_IDLE;
        end
        default: state <= EYE_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/eye_drop_counter.sv
module eye_drop_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             drop,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] TOP = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     count <= '0;
    else if (drop && count != TOP)  count <= count + 1'b1;
  end
endmodule

// File: rtl/eye_serializer.sv
module eye_serializer
  import eye_pkg::*;
#(
  parameter int DIV_HALF = 256,
  parameter int COORD_W  = 8,
  parameter int CNT_W    = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [COORD_W-1:0] in_x,
  input  logic [COORD_W-1:0] in_y,
  output logic               eye_data,
  output logic               eye_clk,
  output logic               eye_strobe,
  output logic [CNT_W-1:0]   drop_count
);
  eye_state_t state;
  logic       tick;
  logic       phase;
  logic       accept;
  logic       drop;
  logic       run;

  assign in_ready   = (state == EYE_IDLE);
  assign accept     = in_valid & in_ready;
  assign drop       = in_valid & ~in_ready;
  assign run        = (state != EYE_IDLE);
  assign eye_clk    = (state == EYE_SHIFT) & phase;
  assign eye_strobe = (state == EYE_LOAD);

  eye_half_timer #(.DIV_HALF(DIV_HALF)) i_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run),
    .tick  (tick),
    .phase (phase)
  );

  eye_frame_ctrl #(.COORD_W(COORD_W)) i_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .accept  (accept),
    .x       (in_x),
    .y       (in_y),
    .tick    (tick),
    .phase   (phase),
    .state   (state),
    .bit_out (eye_data)
  );

  eye_drop_counter #(.CNT_W(CNT_W)) i_drops (
    .clk   (clk),
    .rst_n (rst_n),
    .drop  (drop),
    .count (drop_count)
  );
endmodule

// File: rtl/eye_serializer_chk.sv
module eye_serializer_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             eye_data,
  input logic             eye_clk,
  input logic             eye_strobe,
  input logic [CNT_W-1:0] drop_count
);
  localparam logic [CNT_W-1:0] TOP = '1;

  // R3
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eye_clk && $past(eye_clk)) |-> $stable(eye_data));

  // R4
  idle_clk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !eye_clk);

  // R5
  strobe_clk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eye_strobe |-> (!eye_clk && !in_ready));

  // R6
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  // R7
  drop_incr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready && drop_count != TOP) |=>
      (drop_count == $past(drop_count) + CNT_W'(1)));

  // R8
  drop_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_count == TOP) |=> (drop_count == TOP));

  // R9
  strobe_end_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(eye_strobe) |-> in_ready);
endmodule

bind eye_serializer eye_serializer_chk #(.CNT_W(CNT_W)) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .eye_data   (eye_data),
  .eye_clk    (eye_clk),
  .eye_strobe (eye_strobe),
  .drop_count (drop_count)
);

// File: tb/test_eye_serializer.sv
module test_eye_serializer;
  localparam int H  = 3;
  localparam int CW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [7:0] in_x = '0, in_y = '0;
  logic in_ready, eye_data, eye_clk, eye_strobe;
  logic [CW-1:0] drop_count;

  int checks = 0, errors = 0;

  eye_serializer #(.DIV_HALF(H), .COORD_W(8), .CNT_W(CW)) i_eye_serializer (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_x(in_x), .in_y(in_y), .eye_data(eye_data), .eye_clk(eye_clk),
    .eye_strobe(eye_strobe), .drop_count(drop_count));

  always #4 clk = ~clk;

  // Monitor sampled at the falling system edge
  logic p_clk = 0, p_data = 0, p_strobe = 0;
  logic [15:0] word = 0, last_word = 0;
  int nbits = 0, last_bits = 0, hcnt = 0, lcnt = 0, scnt = 0, last_sw = 0;
  int bad_width = 0, unstable = 0, strobe_clk = 0, bad_start = 0, frames = 0;
  int gap = 0, last_gap = 0;
  logic gapping = 0, ready_at_end = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (eye_clk && !p_clk) begin
        word = {word[14:0], eye_data};
        nbits++;
        if (nbits > 1 && lcnt != H) bad_width++;
        hcnt = 0;
      end
      if (eye_clk) hcnt++;
      if (!eye_clk && p_clk) begin
        if (hcnt != H) bad_width++;
        lcnt = 0;
      end
      if (!eye_clk) lcnt++;
      if (eye_clk && p_clk && eye_data != p_data) unstable++;
      if (eye_strobe && !p_strobe && !(p_clk && !eye_clk)) bad_start++;
      if (eye_strobe) begin
        scnt++;
        if (eye_clk) strobe_clk++;
      end
      if (gapping) begin
        if (eye_clk && !p_clk) begin last_gap = gap + 1; gapping = 0; end
        else gap++;
      end
      if (!eye_strobe && p_strobe) begin
        last_word = word; last_bits = nbits; last_sw = scnt;
        ready_at_end = in_ready;
        word = 0; nbits = 0; scnt = 0; frames++;
        gapping = 1; gap = 0;
      end
      p_clk = eye_clk; p_data = eye_data; p_strobe = eye_strobe;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] x, input logic [7:0] y);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1; in_x = x; in_y = y;
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic wait_frame();
    int f0 = frames;
    for (int i = 0; i < 400 && frames == f0; i++) @(negedge clk);
  endtask

  task automatic frame_checks(input logic [15:0] exp);
    check(last_word == exp, "R2 word", last_word, exp);
    check(last_bits == 16, "R2 bit count", last_bits, 16);
    check(unstable == 0, "R3 data stable while high", unstable, 0);
    check(bad_width == 0, "R4 phase width", bad_width, 0);
    check(last_sw == 2 * H, "R5 strobe width", last_sw, 2 * H);
    check(bad_start == 0 && strobe_clk == 0, "R5 strobe placement", bad_start + strobe_clk, 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(!eye_clk && !eye_data && !eye_strobe, "R1 outputs low",
          {eye_clk, eye_data, eye_strobe}, 0);
    check(in_ready == 1, "R1 ready", in_ready, 1);
    check(drop_count == 0, "R1 drop count", drop_count, 0);
    rst_n = 1;
    @(negedge clk);
    check(!eye_clk && !eye_data && !eye_strobe && in_ready && drop_count == 0,
          "R1 after release", {eye_clk, eye_data, eye_strobe}, 0);
  endtask

  task automatic t_patterns();
    logic [15:0] pats [4] = '{16'hA53C, 16'h807F, 16'hFF00, 16'h01FE};
    for (int i = 0; i < 4; i++) begin
      send(pats[i][15:8], pats[i][7:0]);
      wait_frame();
      frame_checks(pats[i]);
    end
  endtask

  task automatic t_capture();
    @(negedge clk);
    in_valid = 1; in_x = 8'h5A; in_y = 8'hC3;
    @(negedge clk);
    in_valid = 0; in_x = 8'h00; in_y = 8'hFF;
    check(in_ready == 0, "R6 busy after accept", in_ready, 0);
    wait_frame();
    check(last_word == 16'h5AC3, "R6 captured pair", last_word, 16'h5AC3);
  endtask

  task automatic t_drop();
    int f0;
    send(8'h12, 8'h34);
    repeat (10) @(negedge clk);
    in_valid = 1; in_x = 8'hEE; in_y = 8'hEE;
    repeat (2) @(negedge clk);
    in_valid = 0;
    f0 = frames;
    wait_frame();
    check(drop_count == 2, "R7 drop count", drop_count, 2);
    check(last_word == 16'h1234, "R7 frame unaffected", last_word, 16'h1234);
    repeat (120) @(negedge clk);
    check(frames == f0 + 1, "R7 dropped pair not sent", frames, f0 + 1);
  endtask

  task automatic t_saturate();
    send(8'h77, 8'h88);
    repeat (5) @(negedge clk);
    in_valid = 1;
    repeat (30) @(negedge clk);
    in_valid = 0;
    check(drop_count == 7, "R8 saturated", drop_count, 7);
    wait_frame();
    repeat (120) @(negedge clk);
    check(drop_count == 7, "R8 held", drop_count, 7);
  endtask

  task automatic t_back_to_back();
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1; in_x = 8'h3C; in_y = 8'hC3;
    wait_frame();
    check(ready_at_end == 1, "R9 ready at strobe end", ready_at_end, 1);
    wait_frame();
    in_valid = 0;
    check(last_gap == H + 1, "R9 restart gap", last_gap, H + 1);
    check(last_word == 16'h3CC3, "R9 second frame", last_word, 16'h3CC3);
    repeat (250) @(negedge clk);
  endtask

  initial begin
    t_reset();
    t_patterns();
    t_capture();
    t_drop();
    t_saturate();
    t_back_to_back();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule